// File: doc/BRIEF.md
# Lockable Averaging Data Slicer

This block converts a stream of signed discriminator samples into hard decisions. On every symbol strobe the current sample is compared against a decision threshold. While unlocked, that threshold is the mean of the last N accepted samples. A short balanced preamble therefore centres the threshold between the two tone levels.

The threshold can be frozen. After that, long runs of identical bits, or unbalanced payload, no longer pull it away. Freezing happens in one of two ways:
- a lock command from the receiver controller;
- automatically, once the window has filled and a few extra synchronisation symbols have passed.

Automatic freezing does not check that the preamble was real data. The frozen level is held until an explicit unlock, so a receiver that keeps its state can re-enter with only a short synchronisation preamble.

Top module: `avg_slicer`

## Requirements
- R1: After reset, bit_o is 0, locked_o is 0 and thresh_o is 0 (the sample history reads as all zeros).
- R2: On a strobe cycle, bit_o takes the value (sample_i > thresh_o) on the next clock edge, using the threshold in effect during that cycle. A sample exactly equal to the threshold slices to 0.
- R3: While unlocked, thresh_o is the signed sum of the last N strobed samples divided by N, with the quotient truncated toward zero. Slots not yet filled count as zero. N is set by settle_sel_i: 0 gives 11, 1 gives 16, 2 gives 24 and 3 gives 32.
- R4: A sample on a cycle without a strobe has no effect: it changes neither the history (and so not thresh_o) nor bit_o.
- R5: A lock_cmd_i pulse while unlocked copies the current threshold into the frozen level and sets locked_o at the same clock edge. This works in either mode.
- R6: While locked, thresh_o holds the frozen level whatever samples arrive. A run of any length of identical samples is sliced against that level.
- R7: With auto_mode_i = 1, the block locks on the clock edge after the strobe count since reset or unlock reaches N + 3. No check of the data is made.
- R8: An unlock_cmd_i pulse clears locked_o at the next edge and restarts the strobe count. thresh_o immediately returns to the live average. Unlock wins over a lock command in the same cycle.
- R9: With auto_mode_i = 0, the block never locks without a lock_cmd_i pulse, however many strobes arrive.
- R10: A lock_cmd_i pulse while already locked leaves the frozen level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | SAMPLE_W | Signed discriminator sample |
| sym_stb_i | input | 1 | Symbol-centre strobe; sample_i is accepted when high |
| settle_sel_i | input | 2 | Averaging window select (11/16/24/32 symbols) |
| auto_mode_i | input | 1 | 1 = automatic lock after settling, 0 = manual lock |
| lock_cmd_i | input | 1 | One-cycle lock command |
| unlock_cmd_i | input | 1 | One-cycle unlock command |
| bit_o | output | 1 | Sliced bit |
| thresh_o | output | SAMPLE_W | Threshold in effect (live or frozen) |
| locked_o | output | 1 | Threshold frozen |

## Verification
The bench sends samples that equal the threshold exactly; a slicer using greater-or-equal would return 1 for them. It fills the window with negative values whose sums do not divide evenly, so a divider that floors rather than truncates, or that uses the wrong window length, shows up as an off-by-one threshold. After locking it sends forty identical strong symbols and checks that the threshold does not drift, then re-issues lock to catch a design that refreshes the frozen level. In automatic mode it checks that lock is still clear one strobe before the settle count and set on the edge after it. It also checks that manual mode never self-locks and that unlock wins over a simultaneous lock.

// File: rtl/avs_pkg.sv
package avs_pkg;
  localparam int unsigned MAX_WIN   = 32;
  localparam int unsigned SYNC_SYMS = 3;
  localparam int unsigned CNT_W     = 6;

  typedef enum logic [1:0] {
    SETTLE_FAST = 2'd0,
    SETTLE_MID  = 2'd1,
    SETTLE_SLOW = 2'd2,
    SETTLE_MAX  = 2'd3
  } settle_e;

  // window length in symbols for each settle code
  function automatic logic [CNT_W-1:0] win_len(input logic [1:0] sel);
    case (sel)
      SETTLE_FAST: win_len = CNT_W'(11);
      SETTLE_MID:  win_len = CNT_W'(16);
      SETTLE_SLOW: win_len = CNT_W'(24);
      default:     win_len = CNT_W'(32);
    endcase
  endfunction
endpackage

// File: rtl/avs_window.sv
module avs_window
  import avs_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       stb_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [1:0]                 sel_i,
  output logic signed [SAMPLE_W-1:0] avg_o
);
  localparam int unsigned SUM_W = SAMPLE_W + $clog2(MAX_WIN) + 1;

  logic signed [SAMPLE_W-1:0] hist_q [MAX_WIN];
  logic signed [SAMPLE_W-1:0] hist_d [MAX_WIN];
  logic signed [SUM_W-1:0]    sum_w;
  logic signed [SUM_W-1:0]    quot_w [4];

  // history shift, enabled by the strobe
  always_comb begin
    for (int i = 0; i < int'(MAX_WIN); i++) hist_d[i] = hist_q[i];
    if (stb_i) begin
      hist_d[0] = sample_i;
      for (int i = 1; i < int'(MAX_WIN); i++) hist_d[i] = hist_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(MAX_WIN); i++) hist_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(MAX_WIN); i++) hist_q[i] <= hist_d[i];
    end
  end

  // boxcar sum over the selected window
  always_comb begin
    sum_w = '0;
    for (int i = 0; i < int'(MAX_WIN); i++) begin
      if (CNT_W'(i) < win_len(sel_i)) sum_w = sum_w + SUM_W'(hist_q[i]);
    end
  end

  // one constant divider per window length, truncating toward zero
  for (genvar g = 0; g < 4; g++) begin : g_div
    localparam logic signed [SUM_W-1:0] DIVISOR = SUM_W'(win_len(2'(g)));
    assign quot_w[g] = sum_w / DIVISOR;
  end

  assign avg_o = SAMPLE_W'(quot_w[sel_i]);

  // R4: history only moves on a strobe
  p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(hist_q[0]));
endmodule

// File: rtl/avs_lock_ctrl.sv
module avs_lock_ctrl
  import avs_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       stb_i,
  input  logic                       auto_i,
  input  logic                       lock_cmd_i,
  input  logic                       unlock_cmd_i,
  input  logic [1:0]                 sel_i,
  input  logic signed [SAMPLE_W-1:0] live_i,
  output logic                       locked_o,
  output logic signed [SAMPLE_W-1:0] frozen_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0]           cnt_q, cnt_d;
  logic                       locked_q, locked_d;
  logic signed [SAMPLE_W-1:0] frozen_q, frozen_d;
  logic [CNT_W-1:0]           settle_w;
  logic                       auto_hit_w;

  assign settle_w   = win_len(sel_i) + CNT_W'(SYNC_SYMS);
  assign auto_hit_w = auto_i && (cnt_q >= settle_w);

  always_comb begin
    cnt_d    = cnt_q;
    locked_d = locked_q;
    frozen_d = frozen_q;
    if (unlock_cmd_i) begin
      cnt_d    = '0;
      locked_d = 1'b0;
    end else begin
      if (stb_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      if (!locked_q && (lock_cmd_i || auto_hit_w)) begin
        locked_d = 1'b1;
        frozen_d = live_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
      frozen_q <= '0;
    end else begin
      cnt_q    <= cnt_d;
      locked_q <= locked_d;
      frozen_q <= frozen_d;
    end
  end

  assign locked_o = locked_q;
  assign frozen_o = frozen_q;

  // R6 / R10: a held lock keeps its level
  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !unlock_cmd_i) |=> (locked_q && $stable(frozen_q)));
  // R8: unlock always clears
  p_unlock_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_cmd_i |=> !locked_q);
  // R9: manual mode never locks by itself
  p_manual_no_self_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_i && !lock_cmd_i && !locked_q) |=> !locked_q);
  // R7: auto mode waits for the settle count
  p_auto_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked_q && !lock_cmd_i && cnt_q < settle_w) |=> !locked_q);
endmodule

// File: rtl/avs_slicer.sv
module avs_slicer #(
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       stb_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [SAMPLE_W-1:0] thresh_i,
  output logic                       bit_o
);
  logic bit_q, bit_d;

  always_comb begin
    bit_d = bit_q;
    if (stb_i) bit_d = (sample_i > thresh_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  assign bit_o = bit_q;

  // R4: no decision without a strobe
  p_bit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(bit_q));
endmodule

// File: rtl/avg_slicer.sv
module avg_slicer
  import avs_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       sym_stb_i,
  input  logic [1:0]                 settle_sel_i,
  input  logic                       auto_mode_i,
  input  logic                       lock_cmd_i,
  input  logic                       unlock_cmd_i,
  output logic                       bit_o,
  output logic signed [SAMPLE_W-1:0] thresh_o,
  output logic                       locked_o
);
  logic signed [SAMPLE_W-1:0] live_w;
  logic signed [SAMPLE_W-1:0] frozen_w;

  avs_window #(.SAMPLE_W(SAMPLE_W)) u_window (
    .clk(clk), .rst_n(rst_n), .stb_i(sym_stb_i), .sample_i(sample_i),
    .sel_i(settle_sel_i), .avg_o(live_w)
  );

  avs_lock_ctrl #(.SAMPLE_W(SAMPLE_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .stb_i(sym_stb_i), .auto_i(auto_mode_i),
    .lock_cmd_i(lock_cmd_i), .unlock_cmd_i(unlock_cmd_i), .sel_i(settle_sel_i),
    .live_i(live_w), .locked_o(locked_o), .frozen_o(frozen_w)
  );

  assign thresh_o = locked_o ? frozen_w : live_w;

  avs_slicer #(.SAMPLE_W(SAMPLE_W)) u_slice (
    .clk(clk), .rst_n(rst_n), .stb_i(sym_stb_i), .sample_i(sample_i),
    .thresh_i(thresh_o), .bit_o(bit_o)
  );

  // R6: while the lock holds, the published threshold does not move
  p_thresh_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && !unlock_cmd_i) |=> $stable(thresh_o));
endmodule

// File: tb/avg_slicer_tb_top.sv
`timescale 1ns/1ps
module avg_slicer_tb_top;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [SW-1:0] sample_i = '0;
  logic sym_stb_i = 1'b0;
  logic [1:0] settle_sel_i = 2'd0;
  logic auto_mode_i = 1'b0;
  logic lock_cmd_i = 1'b0;
  logic unlock_cmd_i = 1'b0;
  logic bit_o;
  logic signed [SW-1:0] thresh_o;
  logic locked_o;

  always #2.5 clk = ~clk;

  avg_slicer #(.SAMPLE_W(SW)) dut_i (.*);

  int n_chk = 0;
  int n_err = 0;
  bit exp_q[$];
  logic armed_q = 1'b0;

  // model state
  int  m_hist[32];
  int  m_cnt = 0;
  bit  m_locked = 0;
  int  m_frozen = 0;

  function automatic int wlen(input int s);
    case (s) 0: return 11; 1: return 16; 2: return 24; default: return 32; endcase
  endfunction

  function automatic int m_thr();
    int s;
    if (m_locked) return m_frozen;
    s = 0;
    for (int i = 0; i < wlen(int'(settle_sel_i)); i++) s += m_hist[i];
    return s / wlen(int'(settle_sel_i));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // monitor: pop one expected bit per strobe
  always @(posedge clk) armed_q <= sym_stb_i;
  always @(negedge clk) begin
    if (armed_q) begin
      if (exp_q.size() == 0) check(1'b0, "R2 empty queue", int'(bit_o), -1);
      else begin
        bit e;
        e = exp_q.pop_front();
        check(bit_o === e, "R2 sliced bit", int'(bit_o), int'(e));
      end
    end
  end

  // one clock cycle of stimulus; entered and left at posedge+1
  task automatic tick(input bit stb, input int smp, input bit lk, input bit ul);
    int thr;
    sym_stb_i = stb; sample_i = SW'(smp); lock_cmd_i = lk; unlock_cmd_i = ul;
    thr = m_thr();
    if (stb) exp_q.push_back(smp > thr);
    @(posedge clk); #1;
    if (ul) begin m_locked = 0; m_cnt = 0; end
    else begin
      if (stb && m_cnt < 63) m_cnt++;
      if (!m_locked && (lk || (auto_mode_i && (m_cnt - (stb && m_cnt <= 63 ? 1 : 0)) >= wlen(int'(settle_sel_i)) + 3))) begin
        m_locked = 1; m_frozen = thr;
      end
    end
    if (stb) begin
      for (int i = 31; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = smp;
    end
    sym_stb_i = 0; lock_cmd_i = 0; unlock_cmd_i = 0;
  endtask

  task automatic sym(input int smp);
    tick(1'b1, smp, 1'b0, 1'b0);
    tick(1'b0, smp, 1'b0, 1'b0);
  endtask

  task automatic chk_state(input string tag);
    check(int'(thresh_o) == m_thr(), {tag, " threshold"}, int'(thresh_o), m_thr());
    check(locked_o === m_locked, {tag, " locked"}, int'(locked_o), int'(m_locked));
  endtask

  initial begin
    #50000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int hold_thr;
    for (int i = 0; i < 32; i++) m_hist[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check(bit_o === 1'b0, "R1 bit", int'(bit_o), 0);
    chk_state("R1");

    // R3 + R2: alternating preamble, N=11
    for (int i = 0; i < 14; i++) begin
      sym((i % 2) ? -30 : 40);
      chk_state("R3 fill");
    end
    // R2 equality boundary: constant fill gives threshold exactly 10
    for (int i = 0; i < 11; i++) sym(10);
    check(int'(thresh_o) == 10, "R3 const", int'(thresh_o), 10);
    sym(10);   // equal -> 0
    sym(11);   // greater -> 1
    // R4: non-strobe samples ignored
    hold_thr = int'(thresh_o);
    for (int i = 0; i < 5; i++) tick(1'b0, 127, 1'b0, 1'b0);
    check(int'(thresh_o) == hold_thr, "R4 thresh", int'(thresh_o), hold_thr);
    check(bit_o === 1'b1, "R4 bit", int'(bit_o), 1);

    // R5 manual lock
    tick(1'b0, 0, 1'b1, 1'b0);
    chk_state("R5");
    // R6 long run of identical strong symbols, plus below-level run
    for (int i = 0; i < 40; i++) sym(100);
    chk_state("R6 high run");
    for (int i = 0; i < 20; i++) sym(5);
    chk_state("R6 low run");
    // R10 relock ignored
    tick(1'b0, 0, 1'b1, 1'b0);
    chk_state("R10");
    // R8 unlock returns to live average
    tick(1'b0, 0, 1'b0, 1'b1);
    chk_state("R8 unlock");
    // R9 manual mode no self lock
    for (int i = 0; i < 40; i++) sym(-7);
    chk_state("R9");

    // R3 truncation toward zero with other windows
    settle_sel_i = 2'd1;
    for (int i = 0; i < 16; i++) sym((i % 3 == 0) ? -50 : -3);
    chk_state("R3 N16");
    settle_sel_i = 2'd2;
    for (int i = 0; i < 5; i++) sym(-1);
    chk_state("R3 N24");

    // R7 auto lock at N+3 with N=32
    settle_sel_i = 2'd3;
    auto_mode_i = 1'b1;
    tick(1'b0, 0, 1'b0, 1'b1);
    for (int i = 0; i < 34; i++) sym((i % 2) ? 60 : -60);
    chk_state("R7 before");
    tick(1'b1, 60, 1'b0, 1'b0);
    chk_state("R7 at count");
    tick(1'b0, 0, 1'b0, 1'b0);
    check(locked_o === 1'b1, "R7 locked", int'(locked_o), 1);
    chk_state("R7 after");
    for (int i = 0; i < 10; i++) sym(-90);
    chk_state("R7 held");

    // R8 unlock beats lock
    auto_mode_i = 1'b0;
    tick(1'b0, 0, 1'b1, 1'b1);
    chk_state("R8 priority");
    check(locked_o === 1'b0, "R8 priority clear", int'(locked_o), 0);

    repeat (3) @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R2 drained", exp_q.size(), 0);
    finish_run();
  end
endmodule